// File: doc/BRIEF.md
# Sector DMA Command and Status Unit

This block is the register-level front end of a sector-based storage controller. Software, or a bus adapter, writes a memory buffer address, a starting sector number and a sector count through three separate write ports. It then writes a control word that asks for a disk-to-memory read, a memory-to-disk write, or a clear. Parameters and control may be written in the same cycle, and the control then acts on the new values.

The unit checks each start request for a busy controller, a buffer address off the sector boundary, an out-of-range count and a zero count. When a request passes, it starts an external transfer engine with a one-cycle pulse. The engine later reports completion or a memory-side or disk-side range fault. All outcomes are kept in a 16-bit status word holding two busy bits, an exception flag and an 8-bit cause code. The exception is also mirrored on a dedicated output line.

Only one exception is held at a time, and it stays until a clear is written. A completion that lands while another exception is up is held back and raised right after the clear. A clear also aborts a running transfer without producing a completion.

Top module: `blkdev_cmd_unit`

## Requirements
- R1: After reset the status word is 0x0000, `exc_out` is 0 and `xfer_start` is 0.
- R2: A control write with only bit 15 set (read) or only bit 14 set (write), with no exception up, the controller idle, an aligned address and a count from 1 to 256, does three things. One cycle later it sets status bit 15 (read) or bit 14 (write). It pulses `xfer_start` for exactly one cycle, with `xfer_dir` 0 for read and 1 for write. It presents the latched address, sector and count on `xfer_addr`, `xfer_sect` and `xfer_cnt`.
- R3: Address, sector or count values written in the same cycle as a control word are the ones checked and handed to the engine.
- R4: Control bits 12:0 have no effect. A control word with more than one of bits 15:13 set, or a start with a count above 256, raises cause 5 (status reads 0x2005 one cycle later).
- R5: A start whose address has any of bits 8:0 set raises cause 4, and a start with count 0 raises cause 6, both visible one cycle after the write. When several checks fail together, the lowest cause number is reported.
- R6: A start while a transfer is running raises cause 3, and the running transfer keeps its busy bit.
- R7: A completion from the engine while busy, with no exception up, clears the busy bits and raises cause 0 (status 0x2000) one cycle later.
- R8: An engine memory fault (`eng_fault` with `eng_fault_disk` 0) raises cause 1, and a disk fault raises cause 2. The fault clears the busy bits and overwrites any cause already shown.
- R9: A control word with only bit 13 set returns the status to 0x0000 one cycle later. If a transfer was running, it pulses `xfer_abort` for one cycle. An engine completion after that abort has no effect.
- R10: A completion that arrives while an exception is up clears the busy bits and leaves the cause unchanged. The cycle after the next clear, the status shows 0x2000.
- R11: While an exception is up, parameter writes are ignored and read or write commands are ignored. Only a lone clear acts.
- R12: `exc_out` always equals status bit 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Memory address write strobe |
| addr_wdata | input | ADDR_W | Memory address value |
| sect_wr | input | 1 | Sector number write strobe |
| sect_wdata | input | SECT_W | Starting sector value |
| cnt_wr | input | 1 | Sector count write strobe |
| cnt_wdata | input | CNT_W | Sector count value |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | CTL_W | Control word (bit 15 read, 14 write, 13 clear) |
| status | output | 16 | Status word: 15 reading, 14 writing, 13 exception, 7:0 cause |
| exc_out | output | 1 | Exception line, mirror of status bit 13 |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |
| xfer_dir | output | 1 | Transfer direction, 1 = memory to disk |
| xfer_addr | output | ADDR_W | Latched memory address |
| xfer_sect | output | SECT_W | Latched starting sector |
| xfer_cnt | output | CNT_W | Latched sector count |
| xfer_abort | output | 1 | One-cycle abort pulse after a clear during a transfer |
| eng_done | input | 1 | Engine completion pulse |
| eng_fault | input | 1 | Engine range fault pulse |
| eng_fault_disk | input | 1 | Fault kind: 0 memory range, 1 disk range |

## Verification
The bench builds the unit with its default parameters. These are a 32-bit address, a 24-bit sector number, a 256-sector limit that gives a 9-bit count, and 512-byte sectors that make bits 8:0 the alignment field. With these values the count boundary of 256 against 257 and the alignment bit 8 can be driven directly through the ports. The directed scenarios then reach the cause-priority ordering, the held-back completion across a clear, and the suppression of parameter writes while an exception is up.

// File: rtl/blkdev_cmd_pkg.sv
package blkdev_cmd_pkg;
   typedef enum logic [7:0] {
      CZ_DONE       = 8'd0,
      CZ_MEM_RANGE  = 8'd1,
      CZ_DISK_RANGE = 8'd2,
      CZ_BUSY       = 8'd3,
      CZ_ALIGN      = 8'd4,
      CZ_BAD_CMD    = 8'd5,
      CZ_ZERO_CNT   = 8'd6
   } cause_e;

   localparam int CMD_RD_BIT  = 15;
   localparam int CMD_WR_BIT  = 14;
   localparam int CMD_CLR_BIT = 13;
endpackage

// File: rtl/blkdev_param_regs.sv
module blkdev_param_regs #(
   parameter int ADDR_W = 32,
   parameter int SECT_W = 24,
   parameter int CNT_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              addr_we,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic              sect_we,
   input  logic [SECT_W-1:0] sect_d,
   input  logic              cnt_we,
   input  logic [CNT_W-1:0]  cnt_d,
   output logic [ADDR_W-1:0] addr_q,
   output logic [SECT_W-1:0] sect_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [ADDR_W-1:0] addr_eff,
   output logic [CNT_W-1:0]  cnt_eff
);
   logic addr_take, sect_take, cnt_take;

   assign addr_take = addr_we && !lock;
   assign sect_take = sect_we && !lock;
   assign cnt_take  = cnt_we  && !lock;

   // same-cycle values seen by the command checker
   assign addr_eff = addr_take ? addr_d : addr_q;
   assign cnt_eff  = cnt_take  ? cnt_d  : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         sect_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (addr_take) addr_q <= addr_d;
         if (sect_take) sect_q <= sect_d;
         if (cnt_take)  cnt_q  <= cnt_d;
      end
   end
endmodule

// File: rtl/blkdev_cmd_check.sv
module blkdev_cmd_check
   import blkdev_cmd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 9,
   parameter int ALIGN_BITS = 9,
   parameter int MAX_CNT    = 256
) (
   input  logic              ctl_we,
   input  logic [2:0]        cmd,       // {read, write, clear}
   input  logic              exc,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr_eff,
   input  logic [CNT_W-1:0]  cnt_eff,
   output logic              do_clear,
   output logic              do_start,
   output logic              start_wr,
   output logic              err_valid,
   output cause_e            err_cause
);
   logic misalign;
   logic multi;

   generate
      if (ALIGN_BITS > 0) begin : g_align
         assign misalign = |addr_eff[ALIGN_BITS-1:0];
      end else begin : g_noalign
         assign misalign = 1'b0;
      end
   endgenerate

   assign multi = (cmd & (cmd - 3'd1)) != 3'd0;

   always_comb begin
      do_clear  = 1'b0;
      do_start  = 1'b0;
      start_wr  = 1'b0;
      err_valid = 1'b0;
      err_cause = CZ_DONE;
      if (ctl_we && cmd != 3'd0) begin
         if (exc) begin
            do_clear = (cmd == 3'b001);
         end else if (multi) begin
            err_valid = 1'b1;
            err_cause = CZ_BAD_CMD;
         end else if (cmd[0]) begin
            do_clear = 1'b1;
         end else if (busy) begin
            err_valid = 1'b1;
            err_cause = CZ_BUSY;
         end else if (misalign) begin
            err_valid = 1'b1;
            err_cause = CZ_ALIGN;
         end else if (cnt_eff > CNT_W'(MAX_CNT)) begin
            err_valid = 1'b1;
            err_cause = CZ_BAD_CMD;
         end else if (cnt_eff == '0) begin
            err_valid = 1'b1;
            err_cause = CZ_ZERO_CNT;
         end else begin
            do_start = 1'b1;
            start_wr = cmd[1];
         end
      end
   end
endmodule

// File: rtl/blkdev_status_ctl.sv
module blkdev_status_ctl
   import blkdev_cmd_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   do_clear,
   input  logic   do_start,
   input  logic   start_wr,
   input  logic   err_valid,
   input  cause_e err_cause,
   input  logic   eng_done,
   input  logic   eng_fault,
   input  logic   eng_fault_disk,
   output logic   rd_busy,
   output logic   wr_busy,
   output logic   exc,
   output cause_e cause,
   output logic   start_q,
   output logic   dir_q,
   output logic   abort_q
);
   logic pend;
   logic busy, eng_f, eng_d;

   assign busy  = rd_busy || wr_busy;
   assign eng_f = busy && eng_fault;
   assign eng_d = busy && eng_done && !eng_fault;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_busy <= 1'b0;
         wr_busy <= 1'b0;
         exc     <= 1'b0;
         cause   <= CZ_DONE;
         pend    <= 1'b0;
         start_q <= 1'b0;
         dir_q   <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         abort_q <= 1'b0;
         if (do_clear) begin
            rd_busy <= 1'b0;
            wr_busy <= 1'b0;
            exc     <= pend;
            cause   <= CZ_DONE;
            pend    <= 1'b0;
            abort_q <= busy;
         end else if (eng_f) begin
            rd_busy <= 1'b0;
            wr_busy <= 1'b0;
            exc     <= 1'b1;
            cause   <= eng_fault_disk ? CZ_DISK_RANGE : CZ_MEM_RANGE;
         end else if (err_valid) begin
            exc   <= 1'b1;
            cause <= err_cause;
            if (eng_d) begin
               rd_busy <= 1'b0;
               wr_busy <= 1'b0;
               pend    <= 1'b1;
            end
         end else if (eng_d) begin
            rd_busy <= 1'b0;
            wr_busy <= 1'b0;
            if (exc) begin
               pend <= 1'b1;
            end else begin
               exc   <= 1'b1;
               cause <= CZ_DONE;
            end
         end else if (do_start) begin
            rd_busy <= !start_wr;
            wr_busy <= start_wr;
            start_q <= 1'b1;
            dir_q   <= start_wr;
         end
      end
   end
endmodule

// File: rtl/blkdev_cmd_unit.sv
module blkdev_cmd_unit
   import blkdev_cmd_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int SECT_W       = 24,
   parameter int MAX_SECTORS  = 256,
   parameter int SECTOR_BYTES = 512,
   parameter int CTL_W        = 16,
   parameter int CNT_W        = $clog2(MAX_SECTORS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_wr,
   input  logic [ADDR_W-1:0] addr_wdata,
   input  logic              sect_wr,
   input  logic [SECT_W-1:0] sect_wdata,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [15:0]       status,
   output logic              exc_out,
   output logic              xfer_start,
   output logic              xfer_dir,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [SECT_W-1:0] xfer_sect,
   output logic [CNT_W-1:0]  xfer_cnt,
   output logic              xfer_abort,
   input  logic              eng_done,
   input  logic              eng_fault,
   input  logic              eng_fault_disk
);
   localparam int ALIGN_BITS = $clog2(SECTOR_BYTES);

   generate
      if (CTL_W < 16) begin : g_bad_ctl
         $error("CTL_W must cover the command bits");
      end
      if ((1 << ALIGN_BITS) != SECTOR_BYTES) begin : g_bad_sector
         $error("SECTOR_BYTES must be a power of two");
      end
      if (ADDR_W <= ALIGN_BITS) begin : g_bad_addr
         $error("ADDR_W too narrow for the sector size");
      end
      if (CNT_W < $clog2(MAX_SECTORS + 1)) begin : g_bad_cnt
         $error("CNT_W cannot hold MAX_SECTORS");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_eff;
   logic [CNT_W-1:0]  cnt_eff;
   logic              do_clear, do_start, start_wr, err_valid;
   cause_e            err_cause, cause;
   logic              rd_busy, wr_busy, exc;
   logic [2:0]        cmd;

   assign cmd = {ctl_wdata[CMD_RD_BIT], ctl_wdata[CMD_WR_BIT], ctl_wdata[CMD_CLR_BIT]};

   blkdev_param_regs #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .lock(exc),
      .addr_we(addr_wr), .addr_d(addr_wdata),
      .sect_we(sect_wr), .sect_d(sect_wdata),
      .cnt_we(cnt_wr),   .cnt_d(cnt_wdata),
      .addr_q(xfer_addr), .sect_q(xfer_sect), .cnt_q(xfer_cnt),
      .addr_eff(addr_eff), .cnt_eff(cnt_eff)
   );

   blkdev_cmd_check #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ALIGN_BITS(ALIGN_BITS),
                      .MAX_CNT(MAX_SECTORS)) u_check (
      .ctl_we(ctl_wr), .cmd(cmd), .exc(exc), .busy(rd_busy || wr_busy),
      .addr_eff(addr_eff), .cnt_eff(cnt_eff),
      .do_clear(do_clear), .do_start(do_start), .start_wr(start_wr),
      .err_valid(err_valid), .err_cause(err_cause)
   );

   blkdev_status_ctl u_stat (
      .clk(clk), .rst_n(rst_n),
      .do_clear(do_clear), .do_start(do_start), .start_wr(start_wr),
      .err_valid(err_valid), .err_cause(err_cause),
      .eng_done(eng_done), .eng_fault(eng_fault), .eng_fault_disk(eng_fault_disk),
      .rd_busy(rd_busy), .wr_busy(wr_busy), .exc(exc), .cause(cause),
      .start_q(xfer_start), .dir_q(xfer_dir), .abort_q(xfer_abort)
   );

   assign status  = {rd_busy, wr_busy, exc, 5'd0, cause};
   assign exc_out = exc;
endmodule

// File: rtl/blkdev_cmd_sva.sv
module blkdev_cmd_sva #(
   parameter int ADDR_W = 32,
   parameter int SECT_W = 24,
   parameter int CNT_W  = 9,
   parameter int CTL_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_wr,
   input logic [CTL_W-1:0]  ctl_wdata,
   input logic [15:0]       status,
   input logic              exc_out,
   input logic              xfer_start,
   input logic              xfer_abort,
   input logic [ADDR_W-1:0] xfer_addr,
   input logic [SECT_W-1:0] xfer_sect,
   input logic [CNT_W-1:0]  xfer_cnt,
   input logic              eng_done,
   input logic              eng_fault
);
   logic busy;
   logic any_cmd;
   assign busy    = status[15] || status[14];
   assign any_cmd = ctl_wr && (ctl_wdata[15:13] != 3'd0);

   a_r12_exc_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      exc_out == status[13]);

   a_r2_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(status[15:14]));

   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> busy && !exc_out);

   a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);

   a_r9_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[15:13] == 3'b001) |=> !busy && !xfer_start);

   a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_abort |-> !busy);

   a_r11_params_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      exc_out |=> $stable(xfer_addr) && $stable(xfer_sect) && $stable(xfer_cnt));

   a_r7_done_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && !eng_fault && busy && !exc_out && !any_cmd)
      |=> exc_out && status[7:0] == 8'd0 && !busy);

   a_r4_multi_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !exc_out && $countones(ctl_wdata[15:13]) > 1 && !(eng_fault && busy))
      |=> exc_out && status[7:0] == 8'd5);
endmodule

bind blkdev_cmd_unit blkdev_cmd_sva #(
   .ADDR_W(ADDR_W), .SECT_W(SECT_W), .CNT_W(CNT_W), .CTL_W(CTL_W)
) u_sva (
   .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
   .status(status), .exc_out(exc_out), .xfer_start(xfer_start),
   .xfer_abort(xfer_abort), .xfer_addr(xfer_addr), .xfer_sect(xfer_sect),
   .xfer_cnt(xfer_cnt), .eng_done(eng_done), .eng_fault(eng_fault)
);

// File: tb/blkdev_cmd_unit_test.sv
module blkdev_cmd_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_wr = 1'b0;
   logic [31:0] addr_wdata = '0;
   logic        sect_wr = 1'b0;
   logic [23:0] sect_wdata = '0;
   logic        cnt_wr = 1'b0;
   logic [8:0]  cnt_wdata = '0;
   logic        ctl_wr = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [15:0] status;
   logic        exc_out, xfer_start, xfer_dir, xfer_abort;
   logic [31:0] xfer_addr;
   logic [23:0] xfer_sect;
   logic [8:0]  xfer_cnt;
   logic        eng_done = 1'b0;
   logic        eng_fault = 1'b0;
   logic        eng_fault_disk = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   blkdev_cmd_unit uut (
      .clk(clk), .rst_n(rst_n),
      .addr_wr(addr_wr), .addr_wdata(addr_wdata),
      .sect_wr(sect_wr), .sect_wdata(sect_wdata),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .status(status), .exc_out(exc_out),
      .xfer_start(xfer_start), .xfer_dir(xfer_dir),
      .xfer_addr(xfer_addr), .xfer_sect(xfer_sect), .xfer_cnt(xfer_cnt),
      .xfer_abort(xfer_abort),
      .eng_done(eng_done), .eng_fault(eng_fault), .eng_fault_disk(eng_fault_disk)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_st(string req, logic [15:0] exp);
      chk(req, {16'd0, status}, {16'd0, exp});
      chk("R12", {31'd0, exc_out}, {31'd0, exp[13]});
   endtask

   task automatic params(logic [31:0] a, logic [23:0] s, logic [8:0] c);
      addr_wr = 1'b1; addr_wdata = a;
      sect_wr = 1'b1; sect_wdata = s;
      cnt_wr  = 1'b1; cnt_wdata  = c;
      tick();
      addr_wr = 1'b0; sect_wr = 1'b0; cnt_wr = 1'b0;
   endtask

   task automatic ctl(logic [15:0] w);
      ctl_wr = 1'b1; ctl_wdata = w;
      tick();
      ctl_wr = 1'b0; ctl_wdata = '0;
   endtask

   task automatic done_pulse();
      eng_done = 1'b1;
      tick();
      eng_done = 1'b0;
   endtask

   task automatic fault_pulse(logic disk);
      eng_fault = 1'b1; eng_fault_disk = disk;
      tick();
      eng_fault = 1'b0; eng_fault_disk = 1'b0;
   endtask

   task automatic t_reset();
      chk_st("R1 status", 16'h0000);
      chk("R1 start", {31'd0, xfer_start}, 32'd0);
   endtask

   task automatic t_read_ok();
      params(32'h2000, 24'd5, 9'd8);
      ctl(16'h9FFF);                       // R4: bits 12:0 ignored
      chk_st("R2 read busy", 16'h8000);
      chk("R2 start", {31'd0, xfer_start}, 32'd1);
      chk("R2 dir", {31'd0, xfer_dir}, 32'd0);
      chk("R2 addr", xfer_addr, 32'h2000);
      chk("R2 sect", {8'd0, xfer_sect}, 32'd5);
      chk("R2 cnt", {23'd0, xfer_cnt}, 32'd8);
      tick();
      chk("R2 one pulse", {31'd0, xfer_start}, 32'd0);
      done_pulse();
      chk_st("R7 done", 16'h2000);
      ctl(16'h2000);
      chk_st("R9 clear", 16'h0000);
      chk("R9 no abort idle", {31'd0, xfer_abort}, 32'd0);
   endtask

   task automatic t_same_cycle();
      addr_wr = 1'b1; addr_wdata = 32'h3000;
      sect_wr = 1'b1; sect_wdata = 24'd77;
      cnt_wr  = 1'b1; cnt_wdata  = 9'd256;
      ctl(16'h4000);
      addr_wr = 1'b0; sect_wr = 1'b0; cnt_wr = 1'b0;
      chk_st("R3 write busy", 16'h4000);
      chk("R3 dir", {31'd0, xfer_dir}, 32'd1);
      chk("R3 addr", xfer_addr, 32'h3000);
      chk("R3 cnt 256", {23'd0, xfer_cnt}, 32'd256);
      ctl(16'h2000);
      chk_st("R9 clear busy", 16'h0000);
      chk("R9 abort", {31'd0, xfer_abort}, 32'd1);
      done_pulse();
      chk_st("R9 late done ignored", 16'h0000);
      chk("R9 abort one pulse", {31'd0, xfer_abort}, 32'd0);
   endtask

   task automatic t_bad_cmds();
      ctl(16'hC000);
      chk_st("R4 two commands", 16'h2005);
      ctl(16'h2000);
      params(32'h1000, 24'd1, 9'd257);
      ctl(16'h8000);
      chk_st("R4 count 257", 16'h2005);
      ctl(16'h2000);
      ctl(16'hA000);
      chk_st("R4 read plus clear", 16'h2005);
      ctl(16'h2000);
      params(32'h1100, 24'd1, 9'd0);
      ctl(16'h8000);
      chk_st("R5 align before zero", 16'h2004);
      ctl(16'h2000);
      params(32'h1000, 24'd1, 9'd0);
      ctl(16'h4000);
      chk_st("R5 zero count", 16'h2006);
      ctl(16'h2000);
      chk_st("R9 clear", 16'h0000);
   endtask

   task automatic t_busy_pending();
      params(32'h4000, 24'd2, 9'd1);
      ctl(16'h8000);
      chk_st("R2 read", 16'h8000);
      ctl(16'h4000);
      chk_st("R6 busy error", 16'hA003);
      done_pulse();
      chk_st("R10 done held", 16'h2003);
      ctl(16'h2000);
      chk_st("R10 pending raised", 16'h2000);
      ctl(16'h2000);
      chk_st("R10 cleared", 16'h0000);
   endtask

   task automatic t_faults();
      params(32'h1000, 24'd7, 9'd4);
      ctl(16'h8000);
      fault_pulse(1'b0);
      chk_st("R8 mem fault", 16'h2001);
      ctl(16'h2000);
      ctl(16'h4000);
      ctl(16'h8000);
      chk_st("R6 busy error write", 16'h6003);
      fault_pulse(1'b1);
      chk_st("R8 disk fault overwrite", 16'h2002);
   endtask

   task automatic t_locked();
      params(32'h5000, 24'd9, 9'd3);
      ctl(16'h8000);
      chk_st("R11 start ignored", 16'h2002);
      ctl(16'h2000);
      chk_st("R9 clear", 16'h0000);
      ctl(16'h4000);
      chk_st("R11 write ok", 16'h4000);
      chk("R11 addr kept", xfer_addr, 32'h1000);
      chk("R11 sect kept", {8'd0, xfer_sect}, 32'd7);
      chk("R11 cnt kept", {23'd0, xfer_cnt}, 32'd4);
      done_pulse();
      chk_st("R7 done write", 16'h2000);
      ctl(16'h2000);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_read_ok();
      t_same_cycle();
      t_bad_cmds();
      t_busy_pending();
      t_faults();
      t_locked();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule